// File: doc/BRIEF.md
# Next-PC and Exception Unit

This unit owns the program counter of a 32-bit load/store processor with fixed four-byte instructions. Each cycle it looks at the instruction being executed and picks the next PC. The choices are the fall-through address, a PC-relative branch target, a region-local jump target, or a register value. It also drives the return address for a linking call. The datapath supplies an equality flag for branches and the value of the register named by a register jump.

The unit also handles the entry and exit points for interrupts. When an interrupt request is seen, the unit saves the address where execution would have continued into an exception-return register. It then steers the PC to a fixed handler vector. A return strobe sends the PC back to the saved address. The unit has no fetch memory, no register file and no ALU; it drives the PC and reads the current instruction back.

Top module: `npc_ctrl`

## Requirements
- R1: While `rst_n` is low, `pc_o` equals the parameter `RESET_VEC` and `epc_o` is zero.
- R2: An instruction whose opcode (bits 31:26) is not 000010, 000011, 000100 or 000101 advances the PC by 4. The one exception is opcode 000000 with function field (bits 5:0) 001000.
- R3: Opcode 000100 with `eq_flag_i`=1 loads PC+4 plus the sign-extended 16-bit immediate (bits 15:0) shifted left by 2. With `eq_flag_i`=0 it loads PC+4.
- R4: Opcode 000101 is taken, to the same target as R3, when `eq_flag_i`=0. When `eq_flag_i`=1 it loads PC+4.
- R5: Opcode 000010 loads the target formed from bits 31:28 of PC+4, then instruction bits 25:0, then two zero bits.
- R6: Opcode 000011 jumps to the same target as R5. During that cycle it asserts `link_we_o`, with `link_o` equal to PC+4. For every other opcode, `link_we_o` is 0.
- R7: Opcode 000000 with function 001000 loads the PC from `rs_val_i`.
- R8: With `irq_i` high, the next PC is `IRQ_VEC` (default 0x80000180). `epc_o` takes the address the instruction stream would have executed next.
- R9: An interrupt in the same cycle as a taken branch or a jump wins over it. `epc_o` then records that branch or jump target.
- R10: `eret_i` without `irq_i` loads the PC from `epc_o`. With both high, the interrupt wins and `epc_o` keeps its value.
- R11: `epc_o` changes only in a cycle where `irq_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction currently executing at `pc_o` |
| eq_flag_i | input | 1 | Datapath equality result for branches |
| rs_val_i | input | 32 | Source register value for register jumps |
| irq_i | input | 1 | External interrupt request |
| eret_i | input | 1 | Return-from-exception strobe |
| pc_o | output | 32 | Program counter |
| link_o | output | 32 | Return address for a linking jump (PC+4) |
| link_we_o | output | 1 | Return-address write enable |
| epc_o | output | 32 | Saved exception return address |

## Verification
The hardest case is a collision: an interrupt in the same cycle as a control transfer. EPC must then hold the jump target, not PC+4. The bench first brings the PC to a known value through a register jump and an interrupt-return sequence. It then raises the interrupt together with a direct jump, and after that together with a return strobe. This way each saved value is different from the sequential address. The bench also runs a jump from inside the handler region, which shows that the upper four bits of the target follow the PC and are not taken from the instruction.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;
  localparam int IMM_W = 16;
  localparam int IDX_W = 26;

  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_J       = 6'b000010;
  localparam logic [OPC_W-1:0] OPC_JAL     = 6'b000011;
  localparam logic [OPC_W-1:0] OPC_BEQ     = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_BNE     = 6'b000101;
  localparam logic [FN_W-1:0]  FN_JR       = 6'b001000;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_BEQ,
    FLOW_BNE,
    FLOW_J,
    FLOW_JAL,
    FLOW_JR
  } flow_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OPC_W-1:0] op_i,
  input  logic [FN_W-1:0]  fn_i,
  output flow_e            flow_o
);
  always_comb begin
    unique case (op_i)
      OPC_SPECIAL: flow_o = (fn_i == FN_JR) ? FLOW_JR : FLOW_SEQ;
      OPC_J:       flow_o = FLOW_J;
      OPC_JAL:     flow_o = FLOW_JAL;
      OPC_BEQ:     flow_o = FLOW_BEQ;
      OPC_BNE:     flow_o = FLOW_BNE;
      default:     flow_o = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [XLEN-1:0]  seq_o,
  output logic [XLEN-1:0]  br_o,
  output logic [XLEN-1:0]  jmp_o
);
  localparam int STEP     = 4;
  localparam int SEXT_W   = XLEN - IMM_W - 2;
  localparam int REGION_L = IDX_W + 2;

  logic [XLEN-1:0] offs;

  always_comb begin
    seq_o = pc_i + XLEN'(STEP);
    offs  = {{SEXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
    br_o  = seq_o + offs;
    jmp_o = {seq_o[XLEN-1:REGION_L], idx_i, 2'b00};
  end
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter logic [XLEN-1:0] IRQ_VEC = 32'h8000_0180
) (
  input  flow_e           flow_i,
  input  logic            eq_i,
  input  logic            irq_i,
  input  logic            eret_i,
  input  logic [XLEN-1:0] seq_i,
  input  logic [XLEN-1:0] br_i,
  input  logic [XLEN-1:0] jmp_i,
  input  logic [XLEN-1:0] reg_i,
  input  logic [XLEN-1:0] epc_i,
  output logic [XLEN-1:0] stream_o,
  output logic [XLEN-1:0] npc_o
);
  logic [XLEN-1:0] flow_tgt;

  always_comb begin
    unique case (flow_i)
      FLOW_BEQ: flow_tgt = eq_i  ? br_i : seq_i;
      FLOW_BNE: flow_tgt = !eq_i ? br_i : seq_i;
      FLOW_J,
      FLOW_JAL: flow_tgt = jmp_i;
      FLOW_JR:  flow_tgt = reg_i;
      default:  flow_tgt = seq_i;
    endcase
    stream_o = eret_i ? epc_i : flow_tgt;
    npc_o    = irq_i ? IRQ_VEC : stream_o;
  end
endmodule

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0040_0000,
  parameter logic [XLEN-1:0] IRQ_VEC   = 32'h8000_0180
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     instr_i,
  input  logic            eq_flag_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic            irq_i,
  input  logic            eret_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] link_o,
  output logic            link_we_o,
  output logic [XLEN-1:0] epc_o
);
  flow_e           flow;
  logic [XLEN-1:0] seq_a, br_a, jmp_a, stream_a;
  logic [XLEN-1:0] pc_q, pc_d, epc_q, epc_d;
  logic            pc_en, epc_en;

  npc_decode u_dec (
    .op_i   (instr_i[31:26]),
    .fn_i   (instr_i[5:0]),
    .flow_o (flow)
  );

  npc_target #(.XLEN(XLEN)) u_tgt (
    .pc_i  (pc_q),
    .imm_i (instr_i[15:0]),
    .idx_i (instr_i[25:0]),
    .seq_o (seq_a),
    .br_o  (br_a),
    .jmp_o (jmp_a)
  );

  npc_select #(.XLEN(XLEN), .IRQ_VEC(IRQ_VEC)) u_sel (
    .flow_i   (flow),
    .eq_i     (eq_flag_i),
    .irq_i    (irq_i),
    .eret_i   (eret_i),
    .seq_i    (seq_a),
    .br_i     (br_a),
    .jmp_i    (jmp_a),
    .reg_i    (rs_val_i),
    .epc_i    (epc_q),
    .stream_o (stream_a),
    .npc_o    (pc_d)
  );

  // next-state: EPC captures the would-be next address only on interrupt entry
  always_comb begin
    pc_en  = 1'b1;
    epc_en = irq_i;
    epc_d  = stream_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RESET_VEC;
      epc_q <= '0;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (epc_en) epc_q <= epc_d;
    end
  end

  assign pc_o      = pc_q;
  assign epc_o     = epc_q;
  assign link_o    = seq_a;
  assign link_we_o = (flow == FLOW_JAL);
endmodule

// File: rtl/npc_ctrl_chk.sv
module npc_ctrl_chk #(
  parameter int              XLEN    = 32,
  parameter logic [XLEN-1:0] IRQ_VEC = 32'h8000_0180
) (
  input logic            clk,
  input logic            rst_n,
  input logic [31:0]     instr_i,
  input logic            eq_flag_i,
  input logic [XLEN-1:0] rs_val_i,
  input logic            irq_i,
  input logic            eret_i,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] link_o,
  input logic            link_we_o,
  input logic [XLEN-1:0] epc_o
);
  logic [5:0]      opc;
  logic            is_j, is_jal, is_beq, is_jr, is_plain, quiet;
  logic [XLEN-1:0] pc4, jt, bt;

  assign opc      = instr_i[31:26];
  assign is_j     = (opc == 6'b000010);
  assign is_jal   = (opc == 6'b000011);
  assign is_beq   = (opc == 6'b000100);
  assign is_jr    = (opc == 6'b000000) && (instr_i[5:0] == 6'b001000);
  assign is_plain = !is_j && !is_jal && !is_beq && (opc != 6'b000101) && !is_jr;
  assign quiet    = !irq_i && !eret_i;
  assign pc4      = pc_o + 4;
  assign jt       = {pc4[XLEN-1:28], instr_i[25:0], 2'b00};
  assign bt       = pc4 + {{(XLEN-18){instr_i[15]}}, instr_i[15:0], 2'b00};

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && is_plain) |=> (pc_o == $past(pc4)));
  // R3
  beq_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && is_beq && eq_flag_i) |=> (pc_o == $past(bt)));
  // R5
  jump_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && is_j) |=> (pc_o == $past(jt)));
  // R6
  link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_jal |-> (link_we_o && link_o == pc4));
  // R6
  no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_jal |-> !link_we_o);
  // R7
  reg_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && is_jr) |=> (pc_o == $past(rs_val_i)));
  // R8
  irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i |=> (pc_o == IRQ_VEC));
  // R8
  irq_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i && !eret_i && is_plain) |=> (epc_o == $past(pc4)));
  // R10
  eret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_i && !irq_i) |=> (pc_o == $past(epc_o)));
  // R11
  epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_i |=> $stable(epc_o));
endmodule

bind npc_ctrl npc_ctrl_chk #(.XLEN(XLEN), .IRQ_VEC(IRQ_VEC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .instr_i   (instr_i),
  .eq_flag_i (eq_flag_i),
  .rs_val_i  (rs_val_i),
  .irq_i     (irq_i),
  .eret_i    (eret_i),
  .pc_o      (pc_o),
  .link_o    (link_o),
  .link_we_o (link_we_o),
  .epc_o     (epc_o)
);

// File: tb/npc_ctrl_tb.sv
module npc_ctrl_tb;
  localparam int          CLK_P = 10;
  localparam logic [31:0] RST_A = 32'h0040_0000;
  localparam logic [31:0] IRQ_A = 32'h8000_0180;
  localparam logic [31:0] I_ADDI = 32'h2000_0000;
  localparam logic [31:0] I_ADD  = 32'h0000_0020;
  localparam logic [31:0] I_JR31 = 32'h03E0_0008;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] instr, rs_val, pc, link, epc;
  logic        eqf, irq, eret, link_we;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  npc_ctrl #(.RESET_VEC(RST_A), .IRQ_VEC(IRQ_A)) u_dut (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .eq_flag_i(eqf),
    .rs_val_i(rs_val), .irq_i(irq), .eret_i(eret), .pc_o(pc),
    .link_o(link), .link_we_o(link_we), .epc_o(epc)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] br_op(input logic [5:0] op, input logic [15:0] imm);
    return {op, 5'd1, 5'd2, imm};
  endfunction

  function automatic logic [31:0] j_op(input logic [5:0] op, input logic [25:0] idx);
    return {op, idx};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(input logic [31:0] i, input logic e, input logic [31:0] r,
                      input logic q, input logic x);
    instr = i; eqf = e; rs_val = r; irq = q; eret = x;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 pc", pc, RST_A);
    chk("R1 epc", epc, 32'h0);
  endtask

  task automatic t_seq;
    step(I_ADDI, 1'b1, '0, 1'b0, 1'b0);
    chk("R2 addi", pc, RST_A + 4);
    instr = I_ADD; #1;
    chk("R6 no link", {31'b0, link_we}, 32'h0);
    step(I_ADD, 1'b0, '0, 1'b0, 1'b0);
    chk("R2 add", pc, 32'h0040_0008);
  endtask

  task automatic t_beq;
    step(br_op(6'b000100, 16'd3), 1'b1, '0, 1'b0, 1'b0);
    chk("R3 fwd", pc, 32'h0040_0018);
    step(br_op(6'b000100, 16'hFFFE), 1'b1, '0, 1'b0, 1'b0);
    chk("R3 back", pc, 32'h0040_0014);
    step(br_op(6'b000100, 16'd3), 1'b0, '0, 1'b0, 1'b0);
    chk("R3 not taken", pc, 32'h0040_0018);
  endtask

  task automatic t_bne;
    step(br_op(6'b000101, 16'd5), 1'b0, '0, 1'b0, 1'b0);
    chk("R4 taken", pc, 32'h0040_0030);
    step(br_op(6'b000101, 16'd5), 1'b1, '0, 1'b0, 1'b0);
    chk("R4 not taken", pc, 32'h0040_0034);
  endtask

  task automatic t_j;
    step(j_op(6'b000010, 26'h012_3456), 1'b0, '0, 1'b0, 1'b0);
    chk("R5 target", pc, 32'h0048_D158);
    chk("R11 epc idle", epc, 32'h0);
  endtask

  task automatic t_jal;
    instr = j_op(6'b000011, 26'h010_0040); irq = 1'b0; eret = 1'b0; #1;
    chk("R6 we", {31'b0, link_we}, 32'h1);
    chk("R6 link", link, 32'h0048_D15C);
    step(j_op(6'b000011, 26'h010_0040), 1'b0, '0, 1'b0, 1'b0);
    chk("R6 target", pc, 32'h0040_0100);
  endtask

  task automatic t_jr;
    step(I_JR31, 1'b0, 32'h0040_1230, 1'b0, 1'b0);
    chk("R7 pc", pc, 32'h0040_1230);
  endtask

  task automatic t_irq_plain;
    step(I_ADDI, 1'b0, '0, 1'b1, 1'b0);
    chk("R8 vector", pc, IRQ_A);
    chk("R8 epc", epc, 32'h0040_1234);
    step(I_ADDI, 1'b0, '0, 1'b0, 1'b0);
    chk("R11 epc hold", epc, 32'h0040_1234);
    step(j_op(6'b000010, 26'h0), 1'b0, '0, 1'b0, 1'b0);
    chk("R5 upper bits", pc, 32'h8000_0000);
    step(I_ADDI, 1'b0, '0, 1'b0, 1'b1);
    chk("R10 return", pc, 32'h0040_1234);
  endtask

  task automatic t_irq_collide;
    step(j_op(6'b000010, 26'h000_0040), 1'b0, '0, 1'b1, 1'b0);
    chk("R9 pc", pc, IRQ_A);
    chk("R9 epc", epc, 32'h0000_0100);
    step(I_ADDI, 1'b0, '0, 1'b1, 1'b1);
    chk("R10 irq wins pc", pc, IRQ_A);
    chk("R10 irq wins epc", epc, 32'h0000_0100);
    step(I_ADDI, 1'b0, '0, 1'b0, 1'b1);
    chk("R10 eret", pc, 32'h0000_0100);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; instr = I_ADDI; eqf = 1'b0; rs_val = '0; irq = 1'b0; eret = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_seq();
    t_beq();
    t_bne();
    t_j();
    t_jal();
    t_jr();
    t_irq_plain();
    t_irq_collide();
    finish_run();
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule